// File: doc/BRIEF.md
# Nine-bit SPI Command Writer

This block is a transmit-only serial master that programs the control port of a display panel. A requester hands it one request at a time: an 8-bit register address plus a payload of zero, one or two bytes. The block turns the request into a burst of 9-bit words on a three-wire bus (clock, active-low select, data out), where the top bit of each word marks it as a command or as data. The bus has no return line, so the block cannot read back from the panel and cannot tell whether one is attached.

Because the panel cannot be read, the block keeps a local shadow of the last value it wrote to each register address. A requester reads the shadow through a separate combinational read port. The shadow is written only after a request has finished on the wire. An abort input cuts a request short. The block then flags an error and leaves the shadow as it was.

Top module: `spi9_cmd_writer`

## Requirements
- R1: Each word is 9 bits and is sent most significant bit first. Bit 8 is 0 in the address (command) word and 1 in every data word, and bits 7..0 carry the byte.
- R2: The bus uses SPI mode 3. `spi_sclk` is high whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low, so the bit is stable at each rising edge, where the panel samples it.
- R3: `req_len` selects the form: 0 sends the command word alone, 1 sends a command and one data word, 2 sends a command and two data words, and 3 behaves exactly like 2.
- R4: A one-byte request sends `req_data[7:0]`. In a two-byte request the first data word carries `req_data[15:8]` and the second carries `req_data[7:0]`.
- R5: `spi_cs_n` falls before the first bit and stays low across every word of the request. It rises after the last bit and stays high for at least one system clock before the next request pulls it low.
- R6: Each half period of `spi_sclk` lasts `CLK_DIV` system clocks, so consecutive rising edges within a request are 2*`CLK_DIV` clocks apart.
- R7: `req_ready` is high only while the block is idle, and `busy` is its inverse. A request that is held valid while busy is taken only once the current one ends. `done` is a single-cycle pulse at the end of each request.
- R8: When a request completes, the shadow entry for its address takes 0 for a command-only write, the zero-extended byte for a one-byte write, or the full 16-bit value for a two-byte write.
- R9: After reset `spi_cs_n` and `spi_sclk` are high, `req_ready` is high, `busy`, `done` and `error` are low, and every shadow entry reads 0.
- R10: If `abort_req` is high while the select line is low, select is released within one clock. The request then ends with `done` and `error` both high in the same cycle, and the shadow entry is left unchanged.
- R11: The shadow covers addresses 0x00 to 0xED. A request to a higher address is still sent on the bus but stores nothing, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 8 | Target register address |
| req_len | input | 2 | Payload byte count (0, 1, 2; 3 acts as 2) |
| req_data | input | 16 | Payload value |
| abort_req | input | 1 | Cut the current request short |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse at end of request |
| error | output | 1 | Pulses with done when the request was aborted |
| rd_addr | input | 8 | Shadow read address |
| rd_data | output | 16 | Shadow value for rd_addr |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Active-low select |
| spi_mosi | output | 1 | Serial data out |

## Verification
The bench goes after the payload-length edges. With `req_len` at 3, a design that decodes only the low bit would send two words instead of three. With a two-byte value, swapping the bytes would put the low byte first on the wire. With a command-only write, a design that skipped the shadow update would leave a stale value where a 0 belongs. An abort in the middle of a word must release select and leave the shadow unchanged; a design that stored the value anyway, or let `done` pass without `error`, is caught by a readback. Back-to-back requests check that a waiting request is neither lost nor allowed to slip in early. The 0xED and 0xEE addresses check that the last valid entry stores its value and that the next one stores nothing.

// File: rtl/spi9_pkg.sv
package spi9_pkg;

  localparam int WORD_W     = 9;
  localparam int MAX_WORDS  = 3;
  localparam int FRAME_W    = WORD_W * MAX_WORDS;
  localparam int BITCNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    SER_IDLE,
    SER_LEAD,
    SER_LOW,
    SER_HIGH,
    SER_TAIL,
    SER_GAP
  } ser_state_t;

  // Left-aligned frame: command word first, then data words high byte first.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [7:0]  addr,
                                                    input logic [1:0]  len,
                                                    input logic [15:0] val);
    logic [FRAME_W-1:0] f;
    f = '0;
    if (len == 2'd0) begin
      f[FRAME_W-1 -: WORD_W] = {1'b0, addr};
    end else if (len == 2'd1) begin
      f[FRAME_W-1 -: 2*WORD_W] = {1'b0, addr, 1'b1, val[7:0]};
    end else begin
      f = {1'b0, addr, 1'b1, val[15:8], 1'b1, val[7:0]};
    end
    return f;
  endfunction

  function automatic logic [BITCNT_W-1:0] frame_len(input logic [1:0] len);
    logic [BITCNT_W-1:0] n;
    case (len)
      2'd0:    n = BITCNT_W'(WORD_W);
      2'd1:    n = BITCNT_W'(2*WORD_W);
      default: n = BITCNT_W'(3*WORD_W);
    endcase
    return n;
  endfunction

  function automatic logic [15:0] shadow_value(input logic [1:0]  len,
                                               input logic [15:0] val);
    logic [15:0] v;
    case (len)
      2'd0:    v = 16'h0000;
      2'd1:    v = {8'h00, val[7:0]};
      default: v = val;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/spi9_tick.sv
module spi9_tick #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && (cnt_q == '0);
  assign cnt_en = 1'b1;

  always_comb begin
    if (!run || tick) cnt_d = RELOAD;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi9_serializer.sv
module spi9_serializer
  import spi9_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FRAME_W-1:0]  frame,
  input  logic [BITCNT_W-1:0] nbits,
  input  logic                abort,
  input  logic                tick,
  output logic                active,
  output logic                fin,
  output logic                aborted,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi
);

  ser_state_t          st_q, st_d;
  logic [FRAME_W-1:0]  sh_q, sh_d;
  logic [BITCNT_W-1:0] left_q, left_d;
  logic                sclk_d, cs_d, mosi_d, fin_d, abt_d;
  logic                on_wire;

  assign active  = (st_q != SER_IDLE);
  assign on_wire = (st_q == SER_LEAD) || (st_q == SER_LOW) ||
                   (st_q == SER_HIGH) || (st_q == SER_TAIL);

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    left_d = left_q;
    sclk_d = sclk;
    cs_d   = cs_n;
    mosi_d = mosi;
    fin_d  = 1'b0;
    abt_d  = aborted;
    if (st_q == SER_IDLE) begin
      if (start) begin
        st_d   = SER_LEAD;
        sh_d   = frame;
        left_d = nbits;
        cs_d   = 1'b0;
        abt_d  = 1'b0;
      end
    end else if (on_wire && abort) begin
      st_d   = SER_GAP;
      cs_d   = 1'b1;
      sclk_d = 1'b1;
      abt_d  = 1'b1;
    end else if (tick) begin
      case (st_q)
        SER_LEAD, SER_HIGH: begin
          if (left_q != '0) begin
            sclk_d = 1'b0;
            mosi_d = sh_q[FRAME_W-1];
            sh_d   = sh_q << 1;
            left_d = left_q - 1'b1;
            st_d   = SER_LOW;
          end else begin
            st_d   = SER_TAIL;
          end
        end
        SER_LOW: begin
          sclk_d = 1'b1;
          st_d   = SER_HIGH;
        end
        SER_TAIL: begin
          cs_d = 1'b1;
          st_d = SER_GAP;
        end
        SER_GAP: begin
          fin_d = 1'b1;
          st_d  = SER_IDLE;
        end
        default: st_d = SER_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SER_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      sclk    <= 1'b1;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      fin     <= 1'b0;
      aborted <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      sclk    <= sclk_d;
      cs_n    <= cs_d;
      mosi    <= mosi_d;
      fin     <= fin_d;
      aborted <= abt_d;
    end
  end

  assert_clock_idles_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  assert_data_moves_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);

  assert_select_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  assert_abort_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !cs_n) |=> (cs_n && aborted));

endmodule

// File: rtl/spi9_shadow.sv
module spi9_shadow #(
  parameter int NUM_REGS = 238,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [7:0]        raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [NUM_REGS];
  logic              in_range_w, in_range_r;

  assign in_range_w = (32'(waddr) < NUM_REGS);
  assign in_range_r = (32'(raddr) < NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we && in_range_w) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_range_r) rdata = mem_q[raddr];
  end

  assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range_r |-> (rdata == '0));

endmodule

// File: rtl/spi9_cmd_writer.sv
module spi9_cmd_writer
  import spi9_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int NUM_REGS = 238
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_len,
  input  logic [15:0] req_data,
  input  logic        abort_req,
  output logic        busy,
  output logic        done,
  output logic        error,
  input  logic [7:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi
);

  logic        accept, active, tick, fin, aborted;
  logic [7:0]  addr_q;
  logic [15:0] val_q;
  logic        sh_we;

  assign req_ready = !active;
  assign busy      = active;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      val_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      val_q  <= shadow_value(req_len, req_data);
    end
  end

  spi9_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active),
    .tick  (tick)
  );

  spi9_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .frame   (pack_frame(req_addr, req_len, req_data)),
    .nbits   (frame_len(req_len)),
    .abort   (abort_req),
    .tick    (tick),
    .active  (active),
    .fin     (fin),
    .aborted (aborted),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi)
  );

  assign done  = fin;
  assign error = fin && aborted;
  assign sh_we = fin && !aborted;

  spi9_shadow #(.NUM_REGS(NUM_REGS), .DATA_W(16)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sh_we),
    .waddr (addr_q),
    .wdata (val_q),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assert_done_is_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_follows_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_select_only_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

endmodule

// File: tb/sim_spi9_cmd_writer.sv
`timescale 1ns/1ps
module sim_spi9_cmd_writer;

  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [15:0] req_data = '0;
  logic        abort_req = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        req_ready, busy, done, error;
  logic [15:0] rd_data;
  logic        spi_sclk, spi_cs_n, spi_mosi;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  spi9_cmd_writer #(.CLK_DIV(DIV), .NUM_REGS(238)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_len, .req_data,
    .abort_req, .busy, .done, .error, .rd_addr, .rd_data,
    .spi_sclk, .spi_cs_n, .spi_mosi
  );

  // Bus monitor, sampled on the falling system clock edge.
  logic [31:0] cap = '0, fr_val = '0;
  int cap_n = 0, fr_bits = 0, fr_count = 0;
  int cyc = 0, last_rise = 0, rise_gap = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int idle_before_select = 0, min_idle = 1000;

  always @(negedge clk) begin
    if (!spi_cs_n && prev_cs) begin
      cap = '0; cap_n = 0;
      if (idle_before_select < min_idle) min_idle = idle_before_select;
    end
    if (spi_cs_n) idle_before_select++;
    else          idle_before_select = 0;
    if (spi_sclk && !prev_sclk && !spi_cs_n) begin
      cap = {cap[30:0], spi_mosi};
      cap_n++;
      rise_gap = cyc - last_rise;
      last_rise = cyc;
    end
    if (spi_cs_n && !prev_cs) begin
      fr_val = cap; fr_bits = cap_n; fr_count++;
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
    cyc++;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_frame(input logic [7:0] a, input int nb,
                                               input logic [15:0] d);
    logic [31:0] f;
    f = {23'd0, 1'b0, a};
    if (nb >= 1) f = (f << 9) | {23'd0, 1'b1, (nb == 1) ? d[7:0] : d[15:8]};
    if (nb == 2) f = (f << 9) | {23'd0, 1'b1, d[7:0]};
    return f;
  endfunction

  task automatic put_req(input logic [7:0] a, input logic [1:0] l, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit err_seen, input string tag);
    int n;
    n = 0;
    err_seen = 1'b0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, tag, "done seen", done, 1);
    err_seen = error;
    @(negedge clk);
    chk(!done, "R7", "done lasts one cycle", done, 0);
  endtask

  task automatic read_shadow(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk(spi_cs_n === 1'b1, "R9", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sclk === 1'b1, "R9", "sclk after reset", spi_sclk, 1);
    chk(req_ready === 1'b1 && busy === 1'b0, "R9", "ready/busy after reset",
        {req_ready, busy}, 2'b10);
    chk(done === 1'b0 && error === 1'b0, "R9", "done/error after reset", {done, error}, 0);
    read_shadow(8'h11, v);
    chk(v == 16'h0, "R9", "shadow 0x11 after reset", v, 0);
  endtask

  task automatic send_and_check(input logic [7:0] a, input logic [1:0] l,
                                input logic [15:0] d, input string tag);
    bit e;
    int nb, f0;
    logic [31:0] exp;
    nb = (l == 2'd3) ? 2 : int'(l);
    exp = expect_frame(a, nb, d);
    f0 = fr_count;
    put_req(a, l, d);
    wait_done(e, tag);
    chk(!e, tag, "no error", e, 0);
    chk(fr_count == f0 + 1, "R5", "one select window per request", fr_count - f0, 1);
    chk(fr_bits == 9 * (nb + 1), "R3", "bit count", fr_bits, 9 * (nb + 1));
    chk(fr_val == exp, tag, "frame bits (R1 tags, R4 order)", fr_val, exp);
  endtask

  task automatic t_cmd_only;
    logic [15:0] v;
    send_and_check(8'hB0, 2'd1, 16'h0017, "R8");
    read_shadow(8'hB0, v);
    chk(v == 16'h0017, "R8", "one-byte shadow", v, 16'h0017);
    send_and_check(8'hB0, 2'd0, 16'hFFFF, "R1");
    read_shadow(8'hB0, v);
    chk(v == 16'h0000, "R8", "command-only shadow is 0", v, 0);
  endtask

  task automatic t_one_byte;
    logic [15:0] v;
    send_and_check(8'h3A, 2'd1, 16'hAB60, "R4");
    read_shadow(8'h3A, v);
    chk(v == 16'h0060, "R8", "one-byte shadow zero-extended", v, 16'h0060);
    chk(rise_gap == 2 * DIV, "R6", "rising edge spacing", rise_gap, 2 * DIV);
  endtask

  task automatic t_two_byte;
    logic [15:0] v;
    send_and_check(8'hB8, 2'd2, 16'hFFF9, "R4");
    read_shadow(8'hB8, v);
    chk(v == 16'hFFF9, "R8", "two-byte shadow", v, 16'hFFF9);
    send_and_check(8'hC3, 2'd2, 16'h2040, "R4");
  endtask

  task automatic t_len3;
    logic [15:0] v;
    send_and_check(8'hC4, 2'd3, 16'h60C0, "R3");
    read_shadow(8'hC4, v);
    chk(v == 16'h60C0, "R3", "len 3 stores 16 bits", v, 16'h60C0);
  endtask

  task automatic t_held_off;
    bit e;
    int f0;
    logic [15:0] v;
    f0 = fr_count;
    min_idle = 1000;
    put_req(8'h29, 2'd0, 16'h0);
    chk(!req_ready && busy, "R7", "ready low while busy", {req_ready, busy}, 2'b01);
    put_req(8'hC7, 2'd2, 16'h5533);
    chk(fr_count == f0 + 1, "R7", "second request waited for first", fr_count - f0, 1);
    chk(fr_val == expect_frame(8'h29, 0, 16'h0), "R1", "first frame", fr_val,
        expect_frame(8'h29, 0, 16'h0));
    wait_done(e, "R7");
    chk(fr_count == f0 + 2, "R7", "both requests sent", fr_count - f0, 2);
    chk(fr_val == expect_frame(8'hC7, 2, 16'h5533), "R4", "second frame", fr_val,
        expect_frame(8'hC7, 2, 16'h5533));
    chk(min_idle >= 1, "R5", "select high between requests", min_idle, 1);
    read_shadow(8'hC7, v);
    chk(v == 16'h5533, "R8", "queued request shadow", v, 16'h5533);
  endtask

  task automatic t_abort;
    bit e;
    logic [15:0] v;
    send_and_check(8'h20, 2'd2, 16'h1234, "R8");
    put_req(8'h20, 2'd2, 16'hBEEF);
    repeat (20) @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk(spi_cs_n === 1'b1, "R10", "select released after abort", spi_cs_n, 1);
    wait_done(e, "R10");
    chk(e, "R10", "error with done", e, 1);
    chk(fr_bits < 27, "R10", "frame cut short", fr_bits, 27);
    read_shadow(8'h20, v);
    chk(v == 16'h1234, "R10", "shadow unchanged after abort", v, 16'h1234);
    send_and_check(8'h21, 2'd1, 16'h0042, "R10");
  endtask

  task automatic t_range;
    logic [15:0] v;
    send_and_check(8'hED, 2'd2, 16'hABCD, "R11");
    read_shadow(8'hED, v);
    chk(v == 16'hABCD, "R11", "last mapped entry", v, 16'hABCD);
    send_and_check(8'hEE, 2'd1, 16'h0055, "R11");
    read_shadow(8'hEE, v);
    chk(v == 16'h0000, "R11", "unmapped address reads 0", v, 0);
    read_shadow(8'hED, v);
    chk(v == 16'hABCD, "R11", "neighbour untouched", v, 16'hABCD);
    chk(spi_sclk === 1'b1 && spi_cs_n === 1'b1, "R2", "idle bus levels",
        {spi_sclk, spi_cs_n}, 2'b11);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fr_count = 0;
    t_reset();
    t_cmd_only();
    t_one_byte();
    t_two_byte();
    t_len3();
    t_held_off();
    t_abort();
    t_range();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule